// File: doc/BRIEF.md
# Presettable Down-Count Event Counter

This block counts a programmed number of external events. Software or a control sequencer writes a start value through a parallel preset port with a one-cycle strobe. Each later rising edge on an asynchronous pulse line lowers the value by one. The pulse line first passes through a two-flop synchroniser and then a rising-edge detector. A gate input opens and closes acceptance of events. Because the end of the run is always the same state (zero), the run length is set only by the preset value and not by any decode wiring.

Two end-of-run detectors are provided. The first is an all-zero detector: a level flag, plus a single-cycle pulse on the step that reaches zero. The second watches the most significant bit rise, which on a down count happens only when the value wraps from zero to all ones. A mode input chooses between two behaviours at zero. In the halting mode the counter stops there and ignores further events until it is preset again. In the free-running mode it wraps, which is what makes the second detector useful.

Top module: `pulse_downcounter`

## Requirements
- R1: Each accepted event lowers `count_o` by exactly one. An event is a 0-to-1 change of `pulse_in` seen at consecutive clock samples. The new value appears after the third rising clock edge, counting the first edge that samples `pulse_in` high.
- R2: With `halt_at_zero` = 0, an accepted event at value 0 gives all ones (15 for 4 bits).
- R3: `preset_strobe` high at a clock edge copies `preset_value` into `count_o`. This takes priority over an event accepted at the same edge, and that event is lost.
- R4: With `halt_at_zero` = 1 and `count_o` = 0, events are ignored and the value stays 0 until the next preset.
- R5: While `gate_en` is 0, events are ignored and `count_o` holds. Counting resumes from the held value once the gate is 1 again.
- R6: `zero_o` is 1 exactly while `count_o` is 0.
- R7: `done_o` is high for one cycle, the cycle in which an accepted event has just taken the value from 1 to 0. A preset of 0 does not raise it.
- R8: `wrap_o` is high for one cycle, the cycle in which the MSB of `count_o` has just risen because of an accepted event. A preset does not raise it.
- R9: After `rst` the value is 0, `zero_o` is 1, and `done_o` and `wrap_o` are 0.
- R10: A `pulse_in` held high for many cycles counts as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| preset_strobe | input | 1 | Load `preset_value` at this edge |
| preset_value | input | WIDTH | Start value of a run |
| gate_en | input | 1 | 1 = events accepted, 0 = events ignored |
| halt_at_zero | input | 1 | 1 = stop at zero, 0 = wrap to all ones |
| pulse_in | input | 1 | Asynchronous event line |
| count_o | output | WIDTH | Current count value |
| zero_o | output | 1 | Count is zero |
| done_o | output | 1 | One-cycle pulse: count just reached zero by an event |
| wrap_o | output | 1 | One-cycle pulse: MSB just rose on a wrap |

## Verification
A preset appears on `count_o` one edge after the strobe. An event appears on `count_o`, `done_o` and `wrap_o` together, three edges after `pulse_in` is first sampled high: two synchroniser stages plus the count register. The flags are decoded from registers, so they move in the same cycle as the count. The reference model in the bench keeps a short queue of past `pulse_in` samples, so every expected value falls due in the same cycle the design produces it. All outputs are compared at the falling edge, half a period away from any update. Directed checks sit at points where the stimulus has gone quiet for at least three cycles, so each in-flight event has landed.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  // behaviour of the counter when it sits at zero
  typedef enum logic {
    RUN_WRAP = 1'b0,
    RUN_HALT = 1'b1
  } run_mode_e;
endpackage

// File: rtl/dcnt_pulse_qual.sv
module dcnt_pulse_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic edge_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= pulse_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign edge_o = sync_q[LAST] & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o); // R10
endmodule

// File: rtl/dcnt_counter.sv
module dcnt_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] count_o,
  output logic             stepped_o
);
  function automatic logic [WIDTH-1:0] dec_wrap(input logic [WIDTH-1:0] v);
    return v - WIDTH'(1);
  endfunction

  logic [WIDTH-1:0] count_q;
  logic             stepped_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      stepped_q <= 1'b0;
    end else if (load_i) begin
      count_q   <= load_val_i;
      stepped_q <= 1'b0;
    end else if (step_i) begin
      count_q   <= dec_wrap(count_q);
      stepped_q <= 1'b1;
    end else begin
      stepped_q <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign stepped_o = stepped_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (count_o == $past(load_val_i))); // R3
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (count_o == WIDTH'($past(count_o) - 1'b1))); // R1
endmodule

// File: rtl/dcnt_end_detect.sv
module dcnt_end_detect #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] count_i,
  input  logic             stepped_i,
  output logic             zero_o,
  output logic             done_o,
  output logic             wrap_o
);
  localparam int MSB = WIDTH - 1;

  function automatic logic is_zero(input logic [WIDTH-1:0] v);
    return ~(|v);
  endfunction

  logic msb_prev_q;
  logic zero_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_prev_q  <= 1'b0;
      zero_prev_q <= 1'b1;
    end else begin
      msb_prev_q  <= count_i[MSB];
      zero_prev_q <= is_zero(count_i);
    end
  end

  assign zero_o = is_zero(count_i);
  assign done_o = zero_o & ~zero_prev_q & stepped_i;
  assign wrap_o = count_i[MSB] & ~msb_prev_q & stepped_i;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_WRAP_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (count_i == {WIDTH{1'b1}})); // R8
  AST_WRAP_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> ($past(count_i) == '0)); // R2
endmodule

// File: rtl/pulse_downcounter.sv
module pulse_downcounter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preset_strobe,
  input  logic [WIDTH-1:0] preset_value,
  input  logic             gate_en,
  input  logic             halt_at_zero,
  input  logic             pulse_in,
  output logic [WIDTH-1:0] count_o,
  output logic             zero_o,
  output logic             done_o,
  output logic             wrap_o
);
  import dcnt_pkg::*;

  run_mode_e        mode;
  logic             pulse_edge;
  logic             halted;
  logic             step_accept;
  logic             stepped;
  logic [WIDTH-1:0] count_w;
  logic             zero_w;

  assign mode = run_mode_e'(halt_at_zero);

  dcnt_pulse_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .pulse_in (pulse_in),
    .edge_o   (pulse_edge)
  );

  assign halted      = (mode == RUN_HALT) && zero_w;
  assign step_accept = pulse_edge && gate_en && !halted;

  dcnt_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (preset_strobe),
    .load_val_i (preset_value),
    .step_i     (step_accept),
    .count_o    (count_w),
    .stepped_o  (stepped)
  );

  dcnt_end_detect #(.WIDTH(WIDTH)) u_end (
    .clk       (clk),
    .rst       (rst),
    .count_i   (count_w),
    .stepped_i (stepped),
    .zero_o    (zero_w),
    .done_o    (done_o),
    .wrap_o    (wrap_o)
  );

  assign count_o = count_w;
  assign zero_o  = zero_w;

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (halt_at_zero && zero_o && !preset_strobe) |=> zero_o); // R4
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (!gate_en && !preset_strobe) |=> $stable(count_o)); // R5
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (done_o || wrap_o) |-> (zero_o != wrap_o)); // R6
endmodule

// File: tb/test_pulse_downcounter.sv
module test_pulse_downcounter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         preset_strobe;
  logic [W-1:0] preset_value;
  logic         gate_en;
  logic         halt_at_zero;
  logic         pulse_in;
  logic [W-1:0] count_o;
  logic         zero_o, done_o, wrap_o;

  int    tests = 0, fails = 0, cycles = 0;
  int    done_cnt = 0, wrap_cnt = 0;
  bit    checking = 0;
  string phase = "R9";

  // reference model state
  int m_cnt = 0;
  bit m_done = 0, m_wrap = 0;
  int hist[$];

  always #2.5 clk = ~clk;

  pulse_downcounter #(.WIDTH(W), .SYNC_STAGES(2)) i_pulse_downcounter (
    .clk(clk), .rst(rst), .preset_strobe(preset_strobe), .preset_value(preset_value),
    .gate_en(gate_en), .halt_at_zero(halt_at_zero), .pulse_in(pulse_in),
    .count_o(count_o), .zero_o(zero_o), .done_o(done_o), .wrap_o(wrap_o)
  );

  // behavioural model: an event is a 0->1 in samples taken two and three edges ago
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_done = 0; m_wrap = 0;
      hist = '{0, 0, 0};
    end else begin
      bit ev, take;
      ev   = (hist[1] == 1) && (hist[2] == 0);
      take = ev && gate_en && !(halt_at_zero && m_cnt == 0);
      if (preset_strobe) begin
        m_cnt = int'(preset_value); m_done = 0; m_wrap = 0;
      end else if (take) begin
        m_done = (m_cnt == 1);
        m_wrap = (m_cnt == 0);
        m_cnt  = (m_cnt == 0) ? (1 << W) - 1 : m_cnt - 1;
      end else begin
        m_done = 0; m_wrap = 0;
      end
      hist.push_front(int'(pulse_in));
      hist = hist[0:2];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (checking && !rst) begin
      tests++;
      if (int'(count_o) != m_cnt || zero_o != (m_cnt == 0) ||
          done_o != m_done || wrap_o != m_wrap) begin
        fails++;
        $display("FAIL %s cycle %0d: count=%0d zero=%0b done=%0b wrap=%0b expected count=%0d zero=%0b done=%0b wrap=%0b",
                 phase, cycles, count_o, zero_o, done_o, wrap_o,
                 m_cnt, (m_cnt == 0), m_done, m_wrap);
      end
      if (done_o) done_cnt++;
      if (wrap_o) wrap_cnt++;
    end
    if (cycles == 20000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish earlier", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_pulse();
    pulse_in = 1'b1; tick(2);
    pulse_in = 1'b0; tick(3);
  endtask

  task automatic do_load(int v);
    preset_value  = W'(v);
    preset_strobe = 1'b1; tick(1);
    preset_strobe = 1'b0;
  endtask

  initial begin
    rst = 1'b1; preset_strobe = 1'b0; preset_value = '0;
    gate_en = 1'b1; halt_at_zero = 1'b1; pulse_in = 1'b0;
    tick(3);
    rst = 1'b0;
    checking = 1;
    tick(1);
    // R9 reset state
    chk("R9 count", int'(count_o), 0);
    chk("R9 zero", int'(zero_o), 1);
    chk("R9 done/wrap", int'(done_o | wrap_o), 0);

    phase = "R3"; do_load(5);
    chk("R3 preset", int'(count_o), 5);

    phase = "R1"; done_cnt = 0;
    for (int i = 0; i < 5; i++) begin
      one_pulse();
      chk("R1 step", int'(count_o), 4 - i);
    end
    chk("R7 done pulses", done_cnt, 1);
    chk("R6 zero flag", int'(zero_o), 1);

    phase = "R4";
    for (int i = 0; i < 3; i++) one_pulse();
    chk("R4 halted count", int'(count_o), 0);
    chk("R4 no extra done", done_cnt, 1);

    phase = "R5"; do_load(9); gate_en = 1'b0;
    one_pulse(); one_pulse();
    chk("R5 gate closed", int'(count_o), 9);
    gate_en = 1'b1; one_pulse();
    chk("R5 gate reopened", int'(count_o), 8);

    phase = "R10"; pulse_in = 1'b1; tick(10); pulse_in = 1'b0; tick(3);
    chk("R10 long pulse", int'(count_o), 7);

    phase = "R2"; halt_at_zero = 1'b0; do_load(1); wrap_cnt = 0;
    one_pulse();
    chk("R6 zero at 0", int'(zero_o), 1);
    one_pulse();
    chk("R2 wrap value", int'(count_o), 15);
    chk("R8 wrap pulses", wrap_cnt, 1);
    one_pulse();
    chk("R2 continues", int'(count_o), 14);

    phase = "R3";
    pulse_in = 1'b1; tick(2);
    preset_value = 4'd12; preset_strobe = 1'b1; tick(1);
    preset_strobe = 1'b0; pulse_in = 1'b0; tick(3);
    chk("R3 preset beats event", int'(count_o), 12);

    phase = "R7"; halt_at_zero = 1'b1; done_cnt = 0; wrap_cnt = 0;
    do_load(0); tick(2);
    chk("R7 no done on preset 0", done_cnt, 0);
    do_load(8); tick(2);
    chk("R8 no wrap on preset", wrap_cnt, 0);

    tick(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule